// File: doc/BRIEF.md
# Flash Unlock Command Sequence Decoder

This block sits on the byte-write path of a parallel flash device and watches every address/data write. It recognises the keyed multi-write command sequences and turns them into mode changes: the write-protection lock is set or cleared, a chip erase is launched, and an identification mode is entered or left. All sequences share a two-write key (AAh to 5555h, then 55h to 2AAAh). The data of the third write picks either a short three-write command or the extended six-write form, whose sixth write selects the operation. Only address bits 14 to 0 are compared.

Writes that are not part of a command go to the page controller on a one-cycle forwarding port. When the lock is set, they are forwarded only inside a page-load window opened by the lock command; the page controller closes that window with a handshake. Two resets are kept apart. The lock flag survives the ordinary reset, as a non-volatile bit would, and only a separate initialisation reset puts it back to its delivered (locked) state. The identification mode and any partial sequence are lost on the ordinary reset. While identification mode is on, reads of byte 0 and byte 1 return the maker code and the device code.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After the initialisation reset `fact_rst_n` the lock is set (`prot_on`=1), and `id_mode`, `load_open`, `erase_busy`, `erase_start`, `pass_wr` and `id_valid` are all 0.
- R2: The writes AAh@5555h, 55h@2AAAh, A0h@5555h set `prot_on` and `load_open` together, visible in the cycle after the third write.
- R3: While `prot_on`=1 and `load_open`=0, a write that is not a command step is not forwarded: `pass_wr` stays 0.
- R4: While `load_open`=1, every write, including one that looks like a key write, is forwarded in the next cycle with its full address and data, and no command is decoded. A `load_done` pulse clears `load_open`.
- R5: The six writes AA/55/80/AA/55 then 20h, at 5555/2AAA/5555/5555/2AAA/5555, clear `prot_on`. After that, ordinary writes are forwarded in the next cycle.
- R6: The same six-write form ending in 10h gives a one-cycle `erase_start` pulse and holds `erase_busy` high for exactly ERASE_CYCLES cycles. Writes during that time have no effect and are not forwarded.
- R7: The six-write form ending in 60h sets `id_mode`. A read (`rd_en`) of address 0 then gives `id_valid`=1 and `id_data`=DAh one cycle later, address 1 gives C1h, and any other address gives `id_valid`=0.
- R8: The three writes AAh@5555h, 55h@2AAAh, F0h@5555h clear `id_mode`, after which reads give `id_valid`=0.
- R9: A write that breaks an expected step returns the decoder to its start state and does not itself count as a first key write. With the lock clear, it is forwarded as ordinary data.
- R10: The ordinary reset `rst_n` clears `id_mode` and any partial sequence, but leaves `prot_on` unchanged.
- R11: Address bits above bit 14 are ignored when key and command addresses are matched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the volatile state (power event) |
| fact_rst_n | input | 1 | Synchronous active-low initialisation; sets the lock |
| wr_en | input | 1 | Byte write strobe, one cycle per write |
| rd_en | input | 1 | Byte read strobe |
| addr | input | 17 | Byte address for writes and reads |
| wdata | input | 8 | Write data |
| load_done | input | 1 | Page controller ends the page-load window |
| prot_on | output | 1 | Write-protection lock state |
| load_open | output | 1 | Page-load window open under lock |
| erase_start | output | 1 | One-cycle chip erase request |
| erase_busy | output | 1 | Chip erase in progress |
| id_mode | output | 1 | Identification mode active |
| id_valid | output | 1 | `id_data` holds an identification byte |
| id_data | output | 8 | Identification byte |
| pass_wr | output | 1 | Forwarded data write to the page controller |
| pass_addr | output | 17 | Address of the forwarded write |
| pass_data | output | 8 | Data of the forwarded write |

## Verification
Every result of this block is registered once. A mode change, an erase pulse or a forwarded write shows up one cycle after the write that caused it, and an identification byte one cycle after the read strobe. The bench drives each strobe for one cycle starting at a falling edge and samples at the next falling edge, which is the first point where that result is due. A forwarded write is checked by a monitor that pops the expected address and data from a queue at each falling edge where `pass_wr` is high, so an early, late, missing or extra forward shows up as a mismatch. The erase length is measured by counting rising edges from the falling edge where `erase_busy` first reads high until it reads low.

// File: rtl/fcd_pkg.sv
// Package for the flash command decoder.
// Holds the key addresses and data codes, the sequence-step encoding and
// the bundle of one-cycle command strobes passed between the submodules.
package fcd_pkg;

    localparam int DATA_W = 8;
    localparam int CMP_W  = 15;

    localparam logic [CMP_W-1:0] KEY_ADR_A = 15'h5555;
    localparam logic [CMP_W-1:0] KEY_ADR_B = 15'h2AAA;

    localparam logic [DATA_W-1:0] KEY_DAT_A = 8'hAA;
    localparam logic [DATA_W-1:0] KEY_DAT_B = 8'h55;
    localparam logic [DATA_W-1:0] OP_LOCK   = 8'hA0;
    localparam logic [DATA_W-1:0] OP_EXTEND = 8'h80;
    localparam logic [DATA_W-1:0] OP_ID_OUT = 8'hF0;
    localparam logic [DATA_W-1:0] OP_UNLOCK = 8'h20;
    localparam logic [DATA_W-1:0] OP_ERASE  = 8'h10;
    localparam logic [DATA_W-1:0] OP_ID_IN  = 8'h60;

    // step reached so far in the keyed sequence
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_KEY1,
        ST_KEY2,
        ST_EXT,
        ST_KEY4,
        ST_KEY5
    } seq_st_t;

    // one-cycle strobes, at most one high per write
    typedef struct packed {
        logic lock;
        logic unlock;
        logic erase;
        logic id_in;
        logic id_out;
        logic stray;
    } cmd_t;

endpackage

// File: rtl/fcd_seq_fsm.sv
// Sequence tracker for the flash command decoder.
// Follows the keyed write sequence one step per accepted write and emits a
// command strobe in the cycle of the final write. Any write that does not fit
// the expected step raises 'stray' and goes back to idle without being taken
// as a new first key write.
// Assumes: wr_en is one cycle per write; 'active' is low while writes must
// not be decoded (page-load window or erase in progress).
module fcd_seq_fsm
    import fcd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              active,
    input  logic [CMP_W-1:0]  addr_lo,
    input  logic [DATA_W-1:0] wdata,
    output cmd_t              cmd
);

    seq_st_t st_q, st_d;
    logic    at_a, at_b;

    assign at_a = (addr_lo == KEY_ADR_A);
    assign at_b = (addr_lo == KEY_ADR_B);

    // next step and command decode for the current write
    always_comb begin
        st_d = st_q;
        cmd  = '0;
        if (wr_en && active) begin
            st_d      = ST_IDLE;
            cmd.stray = 1'b1;
            unique case (st_q)
                ST_IDLE: if (at_a && wdata == KEY_DAT_A) begin
                    st_d = ST_KEY1; cmd.stray = 1'b0;
                end
                ST_KEY1: if (at_b && wdata == KEY_DAT_B) begin
                    st_d = ST_KEY2; cmd.stray = 1'b0;
                end
                ST_KEY2: if (at_a) begin
                    unique case (wdata)
                        OP_LOCK:   begin cmd.lock   = 1'b1; cmd.stray = 1'b0; end
                        OP_ID_OUT: begin cmd.id_out = 1'b1; cmd.stray = 1'b0; end
                        OP_EXTEND: begin st_d = ST_EXT;     cmd.stray = 1'b0; end
                        default:   ;
                    endcase
                end
                ST_EXT: if (at_a && wdata == KEY_DAT_A) begin
                    st_d = ST_KEY4; cmd.stray = 1'b0;
                end
                ST_KEY4: if (at_b && wdata == KEY_DAT_B) begin
                    st_d = ST_KEY5; cmd.stray = 1'b0;
                end
                ST_KEY5: if (at_a) begin
                    unique case (wdata)
                        OP_UNLOCK: begin cmd.unlock = 1'b1; cmd.stray = 1'b0; end
                        OP_ERASE:  begin cmd.erase  = 1'b1; cmd.stray = 1'b0; end
                        OP_ID_IN:  begin cmd.id_in  = 1'b1; cmd.stray = 1'b0; end
                        default:   ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    // sequence step register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/fcd_mode_regs.sv
// Mode state for the flash command decoder.
// Holds the lock flag (reset only by the initialisation reset), the
// page-load window, the identification mode and the erase busy counter.
// Assumes: command strobes are one cycle wide and mutually exclusive.
module fcd_mode_regs #(
    parameter int ERASE_CYCLES = 64,
    localparam int CNT_W       = $clog2(ERASE_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fact_rst_n,
    input  logic do_lock,
    input  logic do_unlock,
    input  logic do_erase,
    input  logic do_id_in,
    input  logic do_id_out,
    input  logic load_done,
    output logic prot_on,
    output logic load_open,
    output logic id_mode,
    output logic erase_start,
    output logic erase_busy
);

    logic             vol_rst_n;
    logic [CNT_W-1:0] ers_cnt;

    assign vol_rst_n  = rst_n && fact_rst_n;
    assign erase_busy = (ers_cnt != '0);

    // lock flag: kept across the ordinary reset
    always_ff @(posedge clk) begin
        if (!fact_rst_n)    prot_on <= 1'b1;
        else if (do_lock)   prot_on <= 1'b1;
        else if (do_unlock) prot_on <= 1'b0;
    end

    // page-load window opened by the lock command, closed by the page controller
    always_ff @(posedge clk) begin
        if (!vol_rst_n)     load_open <= 1'b0;
        else if (do_lock)   load_open <= 1'b1;
        else if (load_done) load_open <= 1'b0;
    end

    // identification mode, lost on any reset
    always_ff @(posedge clk) begin
        if (!vol_rst_n)     id_mode <= 1'b0;
        else if (do_id_in)  id_mode <= 1'b1;
        else if (do_id_out) id_mode <= 1'b0;
    end

    // erase request pulse and busy countdown
    always_ff @(posedge clk) begin
        if (!vol_rst_n) begin
            erase_start <= 1'b0;
            ers_cnt     <= '0;
        end else begin
            erase_start <= do_erase;
            if (do_erase)        ers_cnt <= CNT_W'(ERASE_CYCLES);
            else if (erase_busy) ers_cnt <= ers_cnt - 1'b1;
        end
    end

endmodule

// File: rtl/fcd_id_reply.sv
// Identification read responder for the flash command decoder.
// In identification mode, a read of byte 0 returns the maker code and a
// read of byte 1 the device code, one cycle after the read strobe. All
// address bits above bit 0 must be zero for a hit.
module fcd_id_reply
    import fcd_pkg::*;
#(
    parameter int                ADDR_W   = 17,
    parameter logic [DATA_W-1:0] MFR_CODE = 8'hDA,
    parameter logic [DATA_W-1:0] DEV_CODE = 8'hC1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              id_mode,
    input  logic [ADDR_W-1:0] addr,
    output logic              id_valid,
    output logic [DATA_W-1:0] id_data
);

    logic hit;

    assign hit = rd_en && id_mode && (addr[ADDR_W-1:1] == '0);

    // registered identification byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_valid <= 1'b0;
            id_data  <= '0;
        end else begin
            id_valid <= hit;
            id_data  <= !hit ? '0 : (addr[0] ? DEV_CODE : MFR_CODE);
        end
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
// Top of the flash command decoder.
// Ties the sequence tracker, the mode registers and the identification
// responder together, and forwards ordinary writes to the page controller:
// all writes inside the page-load window, and stray writes when unlocked.
// Assumes: one write or read strobe per cycle; load_done comes from the page
// controller once it has taken the page.
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int                ADDR_W       = 17,
    parameter int                ERASE_CYCLES = 64,
    parameter logic [DATA_W-1:0] MFR_CODE     = 8'hDA,
    parameter logic [DATA_W-1:0] DEV_CODE     = 8'hC1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fact_rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              load_done,
    output logic              prot_on,
    output logic              load_open,
    output logic              erase_start,
    output logic              erase_busy,
    output logic              id_mode,
    output logic              id_valid,
    output logic [DATA_W-1:0] id_data,
    output logic              pass_wr,
    output logic [ADDR_W-1:0] pass_addr,
    output logic [DATA_W-1:0] pass_data
);

    logic vol_rst_n;
    logic decode_on;
    logic fwd;
    cmd_t cmd;

    assign vol_rst_n = rst_n && fact_rst_n;
    assign decode_on = !load_open && !erase_busy;
    assign fwd       = wr_en && !erase_busy && (load_open || (cmd.stray && !prot_on));

    fcd_seq_fsm u_seq (
        .clk     (clk),
        .rst_n   (vol_rst_n),
        .wr_en   (wr_en),
        .active  (decode_on),
        .addr_lo (addr[CMP_W-1:0]),
        .wdata   (wdata),
        .cmd     (cmd)
    );

    fcd_mode_regs #(.ERASE_CYCLES(ERASE_CYCLES)) u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .fact_rst_n  (fact_rst_n),
        .do_lock     (cmd.lock),
        .do_unlock   (cmd.unlock),
        .do_erase    (cmd.erase),
        .do_id_in    (cmd.id_in),
        .do_id_out   (cmd.id_out),
        .load_done   (load_done),
        .prot_on     (prot_on),
        .load_open   (load_open),
        .id_mode     (id_mode),
        .erase_start (erase_start),
        .erase_busy  (erase_busy)
    );

    fcd_id_reply #(
        .ADDR_W   (ADDR_W),
        .MFR_CODE (MFR_CODE),
        .DEV_CODE (DEV_CODE)
    ) u_id (
        .clk      (clk),
        .rst_n    (vol_rst_n),
        .rd_en    (rd_en),
        .id_mode  (id_mode),
        .addr     (addr),
        .id_valid (id_valid),
        .id_data  (id_data)
    );

    // forwarding register toward the page controller
    always_ff @(posedge clk) begin
        if (!vol_rst_n) begin
            pass_wr   <= 1'b0;
            pass_addr <= '0;
            pass_data <= '0;
        end else begin
            pass_wr <= fwd;
            if (fwd) begin
                pass_addr <= addr;
                pass_data <= wdata;
            end
        end
    end

endmodule

// File: rtl/fcd_checker.sv
// Property checker for the flash command decoder, bound to the top module.
module fcd_checker #(
    parameter int ADDR_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fact_rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        wdata,
    input logic              prot_on,
    input logic              load_open,
    input logic              erase_start,
    input logic              erase_busy,
    input logic              id_mode,
    input logic              id_valid,
    input logic              pass_wr,
    input logic [ADDR_W-1:0] pass_addr,
    input logic [7:0]        pass_data
);

    a_r3_locked_no_forward: assert property (@(posedge clk) disable iff (!rst_n || !fact_rst_n)
        (prot_on && !load_open) |=> !pass_wr);

    a_r4_window_forward: assert property (@(posedge clk) disable iff (!rst_n || !fact_rst_n)
        (load_open && wr_en && !erase_busy) |=>
            (pass_wr && pass_addr == $past(addr) && pass_data == $past(wdata)));

    a_r6_start_single: assert property (@(posedge clk) disable iff (!rst_n || !fact_rst_n)
        erase_start |=> !erase_start);

    a_r6_start_busy: assert property (@(posedge clk) disable iff (!rst_n || !fact_rst_n)
        erase_start |-> erase_busy);

    a_r6_busy_no_forward: assert property (@(posedge clk) disable iff (!rst_n || !fact_rst_n)
        erase_busy |=> !pass_wr);

    a_r7_id_needs_mode: assert property (@(posedge clk) disable iff (!rst_n || !fact_rst_n)
        (!id_mode || !rd_en) |=> !id_valid);

    a_r10_lock_kept: assert property (@(posedge clk) disable iff (!fact_rst_n)
        !rst_n |=> (prot_on == $past(prot_on)));

endmodule

bind flash_cmd_decoder fcd_checker #(.ADDR_W(ADDR_W)) u_fcd_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fact_rst_n  (fact_rst_n),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .addr        (addr),
    .wdata       (wdata),
    .prot_on     (prot_on),
    .load_open   (load_open),
    .erase_start (erase_start),
    .erase_busy  (erase_busy),
    .id_mode     (id_mode),
    .id_valid    (id_valid),
    .pass_wr     (pass_wr),
    .pass_addr   (pass_addr),
    .pass_data   (pass_data)
);

// File: tb/test_flash_cmd_decoder.sv
// Scoreboard bench for the flash command decoder.
module test_flash_cmd_decoder;

    localparam int AW = 17;
    localparam int NE = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fact_rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic          load_done = 1'b0;
    logic          prot_on, load_open, erase_start, erase_busy, id_mode, id_valid, pass_wr;
    logic [7:0]    id_data, pass_data;
    logic [AW-1:0] pass_addr;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;
    logic [AW+7:0] exp_q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    flash_cmd_decoder #(.ADDR_W(AW), .ERASE_CYCLES(NE)) i_flash_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .fact_rst_n(fact_rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .load_done(load_done), .prot_on(prot_on),
        .load_open(load_open), .erase_start(erase_start), .erase_busy(erase_busy),
        .id_mode(id_mode), .id_valid(id_valid), .id_data(id_data), .pass_wr(pass_wr),
        .pass_addr(pass_addr), .pass_data(pass_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one write; 'fw' pushes it as an expected forward
    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input bit fw);
        if (fw) exp_q.push_back({a, d});
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic key(input logic [AW-1:0] hi);
        wr(hi | 17'h05555, 8'hAA, 1'b0);
        wr(hi | 17'h02AAA, 8'h55, 1'b0);
    endtask

    task automatic six(input logic [7:0] op, input logic [AW-1:0] hi);
        key(hi);
        wr(hi | 17'h05555, 8'h80, 1'b0);
        key(hi);
        wr(hi | 17'h05555, op, 1'b0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    endtask

    // monitor: pop and compare each forwarded write
    always @(negedge clk) begin
        if (rst_n && fact_rst_n && pass_wr) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R3 unexpected forward actual=%0h/%0h expected=none", pass_addr, pass_data);
            end else begin
                logic [AW+7:0] e;
                e = exp_q.pop_front();
                if ({pass_addr, pass_data} !== e) begin
                    n_fail++;
                    $display("FAIL R4/R5/R9 forward actual=%0h expected=%0h", {pass_addr, pass_data}, e);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        int c0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; fact_rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 prot_on", prot_on, 1);
        chk("R1 idle outputs", {id_mode, load_open, erase_busy, erase_start, pass_wr, id_valid}, 0);

        // R3 locked: stray write not forwarded
        wr(17'h00123, 8'h5A, 1'b0);
        chk("R3 no forward", pass_wr, 0);

        // R2 lock sequence opens window
        key(17'h0);
        wr(17'h05555, 8'hA0, 1'b0);
        chk("R2 prot_on", prot_on, 1);
        chk("R2 load_open", load_open, 1);

        // R4 window forwards everything, no decode
        wr(17'h00007, 8'h11, 1'b1);
        wr(17'h05555, 8'hAA, 1'b1);
        chk("R4 forward seen", pass_wr, 1);
        @(negedge clk); load_done = 1'b1;
        @(negedge clk); load_done = 1'b0;
        chk("R4 window closed", load_open, 0);
        wr(17'h00009, 8'h44, 1'b0);
        chk("R3 no forward after window", pass_wr, 0);

        // R5 and R11: unlock with high address bits set
        six(8'h20, 17'h18000);
        chk("R5 R11 prot_on cleared", prot_on, 0);
        wr(17'h00042, 8'h77, 1'b1);
        chk("R5 forward when unlocked", pass_wr, 1);

        // R9 broken sequence
        key(17'h0);
        wr(17'h00100, 8'h33, 1'b1);
        wr(17'h05555, 8'hA0, 1'b1);
        chk("R9 no lock after break", prot_on, 0);

        // R7 identification mode
        six(8'h60, 17'h0);
        chk("R7 id_mode", id_mode, 1);
        rd(17'h00000);
        chk("R7 maker code", {id_valid, id_data}, 9'h1DA);
        rd(17'h00001);
        chk("R7 device code", {id_valid, id_data}, 9'h1C1);
        rd(17'h00002);
        chk("R7 other address", id_valid, 0);

        // R10 soft reset
        key(17'h0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R10 id_mode cleared", id_mode, 0);
        chk("R10 lock kept clear", prot_on, 0);
        wr(17'h05555, 8'hA0, 1'b1);
        chk("R10 partial sequence lost", prot_on, 0);

        // R8 exit identification mode
        six(8'h60, 17'h0);
        key(17'h0);
        wr(17'h05555, 8'hF0, 1'b0);
        chk("R8 id_mode cleared", id_mode, 0);
        rd(17'h00000);
        chk("R8 no id reply", id_valid, 0);

        // R6 chip erase
        six(8'h10, 17'h0);
        chk("R6 erase_start", erase_start, 1);
        chk("R6 erase_busy", erase_busy, 1);
        c0 = cyc;
        wr(17'h00055, 8'h99, 1'b0);
        chk("R6 start one cycle", erase_start, 0);
        chk("R6 write ignored", pass_wr, 0);
        while (erase_busy) @(negedge clk);
        chk("R6 busy length", cyc - c0, NE);

        repeat (2) @(negedge clk);
        chk("R4 R5 R9 queue drained", exp_q.size(), 0);
        finish_run();
    end

endmodule